// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one two-wire management transaction to a PHY. A request carries a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block builds a clause-22 style frame from that request. It derives the management clock MDC from the system clock. It drives the data line through an output-enable and releases the line whenever it expects the PHY to talk. When the frame ends it raises `done` for exactly one cycle, and on a read `rd_data` holds the register contents at that point. A new request is taken only while `busy` is low.

The frame is sequenced by a state machine with the states ST_IDLE, ST_PRE, ST_SOF, ST_OP, ST_PHY, ST_REG, ST_WTA, ST_WDAT, ST_RSMP, ST_RTAIL and ST_DONE.
- An accepted request moves ST_IDLE to ST_PRE.
- At the end of each bit period the machine counts down inside its current state. On the last bit of that state it takes the next transition: ST_PRE to ST_SOF, ST_SOF to ST_OP, ST_OP to ST_PHY, then ST_PHY to ST_REG.
- From ST_REG, a write goes to ST_WTA, then ST_WDAT, then ST_DONE.
- From ST_REG, a read goes to ST_RSMP, then ST_RTAIL, then ST_DONE.
- ST_DONE always returns to ST_IDLE after one cycle.

Incoming data passes through a two-flop synchroniser. The sample point is placed that many system cycles after the MDC rising edge.

Top module: `mdio_master`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `mdc` is low, `mdio_oe` is low and `done` is low.
- R2: Each frame opens with 32 MDC periods in which the line is driven (`mdio_oe`=1) with `mdio_o`=1.
- R3: After the 32 preamble bits come the start bits 0 then 1, then a 2-bit opcode: 1,0 for a read (`req_rd`=1) and 0,1 for a write.
- R4: After the opcode, the master sends the 5-bit PHY address and then the 5-bit register address, each MSB first, with the line driven.
- R5: A write sends the turnaround bits 1 then 0 and the 16 data bits MSB first, all driven. The frame totals 64 MDC rising edges, after which the line is released.
- R6: A read releases the line from bit 46, counting from 0 at the first preamble bit, to the end of the frame. It samples 17 bits at bit positions 46 to 62 and discards the first of them. `rd_data` is the last 16 samples, with the first of these landing in bit 15. The read frame has two more released MDC periods after the samples, for 65 MDC rising edges in total.
- R7: Each MDC high phase and each MDC low phase lasts HALF_EFF system cycles. HALF_EFF is the larger of HALF_CYC and the smallest count that keeps the MDC period at or above MIN_MDC_NS. `mdio_o` and `mdio_oe` change only while MDC is low.
- R8: A request raised while `busy` is high is ignored. The running frame keeps its fields, and no extra frame follows it.
- R9: `done` is a one-cycle pulse, raised 2·HALF_EFF·N cycles after the accepting edge, where N is 64 for a write and 65 for a read. `busy` falls on the cycle after `done`. After a write, `rd_data` reads 0.
- R10: Each read sample is the level of `mdio_i` at the MDC rising edge, taken through a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a frame (taken only when busy is low) |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a running frame. It must be dropped without disturbing the latched fields or queuing a second frame. The bench raises such a request with different fields partway through a frame. It then checks that the frame carries the original address and data bits, that exactly 64 rising edges appear and that the latency is unchanged. A second hard case is the discarded turnaround sample. The bench's PHY model drives the inverse of the first data bit in that slot, so a read that keeps the wrong 16 of its 17 samples shows up in `rd_data`.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int BCNT_W  = 5;

    localparam logic [1:0] SOF_PAT = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] TA_WR   = 2'b10;

    localparam logic [BCNT_W-1:0] PRE_LAST  = 5'd31;
    localparam logic [BCNT_W-1:0] PAIR_LAST = 5'd1;
    localparam logic [BCNT_W-1:0] ADDR_LAST = 5'd4;
    localparam logic [BCNT_W-1:0] DATA_LAST = 5'd15;
    localparam logic [BCNT_W-1:0] RSMP_LAST = 5'd16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_SOF,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_WTA,
        ST_WDAT,
        ST_RSMP,
        ST_RTAIL,
        ST_DONE
    } mdio_state_e;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF      = 25,
    parameter int SAMPLE_AT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic bit_end,
    output logic sample_stb
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] SMP  = CNT_W'(SAMPLE_AT);

    logic [CNT_W-1:0] cnt_q;
    logic             ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            ph_q  <= ~ph_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc        = ph_q;
    assign bit_end    = run & ph_q & (cnt_q == LAST);
    assign sample_stb = run & ph_q & (cnt_q == SMP);

endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_master_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              bit_end,
    input  logic              sample_stb,
    input  logic              din,
    output logic              run,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    mdio_state_e       state_q, state_d;
    logic [BCNT_W-1:0] bit_q, bit_d;
    logic              rd_q;
    logic [ADDR_W-1:0] phy_q, reg_q;
    logic [DATA_W-1:0] wdat_q, rx_q;
    logic              drv_val, drv_en;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && req;

    // next-state logic
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = ST_PRE;
                    bit_d   = PRE_LAST;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
                bit_d   = '0;
            end
            default: begin
                if (bit_end) begin
                    if (bit_q != '0) begin
                        bit_d = bit_q - 1'b1;
                    end else begin
                        unique case (state_q)
                            ST_PRE:   begin state_d = ST_SOF;  bit_d = PAIR_LAST; end
                            ST_SOF:   begin state_d = ST_OP;   bit_d = PAIR_LAST; end
                            ST_OP:    begin state_d = ST_PHY;  bit_d = ADDR_LAST; end
                            ST_PHY:   begin state_d = ST_REG;  bit_d = ADDR_LAST; end
                            ST_REG: begin
                                if (rd_q) begin
                                    state_d = ST_RSMP;
                                    bit_d   = RSMP_LAST;
                                end else begin
                                    state_d = ST_WTA;
                                    bit_d   = PAIR_LAST;
                                end
                            end
                            ST_WTA:   begin state_d = ST_WDAT;  bit_d = DATA_LAST; end
                            ST_WDAT:  begin state_d = ST_DONE;  bit_d = '0; end
                            ST_RSMP:  begin state_d = ST_RTAIL; bit_d = PAIR_LAST; end
                            ST_RTAIL: begin state_d = ST_DONE;  bit_d = '0; end
                            default:  begin state_d = ST_IDLE;  bit_d = '0; end
                        endcase
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
        end
    end

    // request capture and receive shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            phy_q  <= '0;
            reg_q  <= '0;
            wdat_q <= '0;
            rx_q   <= '0;
        end else if (accept) begin
            rd_q   <= req_rd;
            phy_q  <= req_phy;
            reg_q  <= req_reg;
            wdat_q <= req_wdata;
            rx_q   <= '0;
        end else if ((state_q == ST_RSMP) && sample_stb) begin
            rx_q   <= {rx_q[DATA_W-2:0], din};
        end
    end

    // line value for the current bit
    always_comb begin
        drv_val = 1'b0;
        drv_en  = 1'b1;
        unique case (state_q)
            ST_PRE:  drv_val = 1'b1;
            ST_SOF:  drv_val = SOF_PAT[bit_q[0]];
            ST_OP:   drv_val = rd_q ? OP_RD[bit_q[0]] : OP_WR[bit_q[0]];
            ST_PHY:  drv_val = phy_q[bit_q[2:0]];
            ST_REG:  drv_val = reg_q[bit_q[2:0]];
            ST_WTA:  drv_val = TA_WR[bit_q[0]];
            ST_WDAT: drv_val = wdat_q[bit_q[3:0]];
            default: drv_en  = 1'b0;
        endcase
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else begin
            mdio_o  <= drv_en & drv_val;
            mdio_oe <= drv_en;
        end
    end

    assign run     = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_DONE);
    assign rd_data = rx_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_master_pkg::*;
#(
    parameter int HALF_CYC     = 25,
    parameter int CLK_PERIOD_PS = 8000,
    parameter int MIN_MDC_NS   = 400,
    parameter int SYNC_STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        req_rd,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int MIN_HALF = (MIN_MDC_NS * 1000 + 2 * CLK_PERIOD_PS - 1) / (2 * CLK_PERIOD_PS);
    localparam int HALF_LO  = (HALF_CYC < MIN_HALF) ? MIN_HALF : HALF_CYC;
    localparam int HALF_EFF = (HALF_LO <= SYNC_STAGES) ? SYNC_STAGES + 1 : HALF_LO;

    logic run, bit_end, sample_stb, din_s;

    mdio_mdc_gen #(
        .HALF      (HALF_EFF),
        .SAMPLE_AT (SYNC_STAGES)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .mdc        (mdc),
        .bit_end    (bit_end),
        .sample_stb (sample_stb)
    );

    mdio_in_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mdio_i),
        .dout  (din_s)
    );

    mdio_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_rd     (req_rd),
        .req_phy    (req_phy),
        .req_reg    (req_reg),
        .req_wdata  (req_wdata),
        .bit_end    (bit_end),
        .sample_stb (sample_stb),
        .din        (din_s),
        .run        (run),
        .busy       (busy),
        .done       (done),
        .rd_data    (rd_data),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int HALF_EFF = 25
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    localparam int LEN_W = $clog2(HALF_EFF + 2);
    logic [LEN_W-1:0] hi_len;
    logic [LEN_W-1:0] lo_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len <= '0;
            lo_len <= '0;
        end else begin
            hi_len <= mdc ? hi_len + 1'b1 : '0;
            lo_len <= (!mdc && busy) ? lo_len + 1'b1 : '0;
        end
    end

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R1
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !done)); // R1
    AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_len == LEN_W'(HALF_EFF))); // R7
    AST_LOW_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> (lo_len == LEN_W'(HALF_EFF))); // R7
    AST_LINE_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_BUSY_DROP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9
    AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !mdc)); // R9

endmodule

bind mdio_master mdio_master_chk #(
    .HALF_EFF (HALF_EFF)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;

    localparam int H = 25;  // expected effective half period (HALF_CYC=4 is below minimum)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_rd = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mdio_master #(
        .HALF_CYC      (4),
        .CLK_PERIOD_PS (8000),
        .MIN_MDC_NS    (400),
        .SYNC_STAGES   (2)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_rd    (req_rd),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    // PHY model: captures bits at MDC rise, answers reads after MDC fall
    logic [15:0] phy_mem [32];
    logic [15:0] exp_mem [32];
    logic        bv [80];
    logic        bo [80];
    int          nrise = 0;

    function automatic logic [15:0] init_val(input int r);
        return 16'(r * 16'h0911) ^ 16'hC33C;
    endfunction

    function automatic logic [4:0] cap5(input int first);
        logic [4:0] v;
        for (int i = 0; i < 5; i++) v[4-i] = bv[first+i];
        return v;
    endfunction

    always @(posedge mdc) begin
        if (nrise < 80) begin
            bv[nrise] = mdio_o;
            bo[nrise] = mdio_oe;
        end
        nrise = nrise + 1;
    end

    always @(negedge mdc) begin
        #2;
        if (nrise >= 46 && nrise <= 62 && bv[34] && !bv[35]) begin
            logic [15:0] d;
            d = phy_mem[cap5(41)];
            if (nrise == 46) mdio_i = ~d[15];
            else             mdio_i = d[62-nrise];
        end else begin
            mdio_i = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input bit inject);
        int k;
        int hi_cnt;
        int viol;
        int nbits;
        bit pm, po, poe, pre_ok, oe_ok;
        logic [15:0] dcap;
        nbits = rd ? 65 : 64;
        nrise = 0;
        @(negedge clk);
        req = 1'b1; req_rd = rd; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(posedge clk); #1;
        k = 0; hi_cnt = 0; viol = 0;
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        pm = mdc; po = mdio_o; poe = mdio_oe;
        @(negedge clk);
        req = 1'b0;
        while (!done && k < 10000) begin
            @(posedge clk); #1;
            k++;
            if (mdc) hi_cnt++;
            if (pm && mdc && (po != mdio_o || poe != mdio_oe)) viol++;
            pm = mdc; po = mdio_o; poe = mdio_oe;
            if (inject && k == 100) begin
                req = 1'b1; req_rd = ~rd; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
            end
            if (inject && k == 101) req = 1'b0;
        end
        chk(k == 2 * H * nbits, "R9 done latency", k, 2 * H * nbits);
        chk(hi_cnt == H * nbits, "R7 mdc high cycles", hi_cnt, H * nbits);
        chk(viol == 0, "R7 line changed while mdc high", viol, 0);
        if (!rd) chk(rd_data == 16'h0000, "R9 rd_data after write", rd_data, 0);
        else     chk(rd_data == exp_mem[rg], "R6 R10 read data", rd_data, exp_mem[rg]);
        @(posedge clk); #1;
        chk(!done && !busy, "R9 done one cycle then idle", {done, busy}, 0);
        chk(!mdc && !mdio_oe, "R1 idle mdc low line released", {mdc, mdio_oe}, 0);
        if (inject) begin
            repeat (4 * H) @(posedge clk);
            #1;
        end
        chk(nrise == nbits, "R5 R6 R8 mdc rising edges", nrise, nbits);
        pre_ok = 1'b1;
        for (int i = 0; i < 32; i++) if (!bv[i] || !bo[i]) pre_ok = 1'b0;
        chk(pre_ok, "R2 preamble", pre_ok, 1);
        chk({bv[32], bv[33]} == 2'b01, "R3 start bits", {bv[32], bv[33]}, 1);
        chk({bv[34], bv[35]} == (rd ? 2'b10 : 2'b01), "R3 opcode", {bv[34], bv[35]}, rd ? 2 : 1);
        chk(cap5(36) == phy, "R4 R8 phy address", cap5(36), phy);
        chk(cap5(41) == rg, "R4 R8 register address", cap5(41), rg);
        oe_ok = 1'b1;
        for (int i = 0; i < 46; i++) if (!bo[i]) oe_ok = 1'b0;
        if (rd) begin
            for (int i = 46; i < 65; i++) if (bo[i]) oe_ok = 1'b0;
            chk(oe_ok, "R6 release pattern", oe_ok, 1);
        end else begin
            for (int i = 46; i < 64; i++) if (!bo[i]) oe_ok = 1'b0;
            chk(oe_ok, "R5 drive pattern", oe_ok, 1);
            chk({bv[46], bv[47]} == 2'b10, "R5 turnaround", {bv[46], bv[47]}, 2);
            for (int i = 0; i < 16; i++) dcap[15-i] = bv[48+i];
            chk(dcap == wd, "R5 R8 write data", dcap, wd);
            phy_mem[cap5(41)] = dcap;
            exp_mem[rg] = wd;
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < 32; r++) begin
            phy_mem[r] = init_val(r);
            exp_mem[r] = init_val(r);
        end
        repeat (3) @(posedge clk);
        #1;
        chk(!mdc && !mdio_oe && !busy && !done, "R1 reset state",
            {mdc, mdio_oe, busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(!mdc && !mdio_oe && !busy && !done, "R1 idle after reset",
            {mdc, mdio_oe, busy, done}, 0);

        run_frame(1'b0, 5'h00, 5'h00, 16'h0000, 1'b0);
        run_frame(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 1'b0);
        run_frame(1'b0, 5'h15, 5'h0A, 16'hA5A5, 1'b1);
        run_frame(1'b0, 5'h0A, 5'h15, 16'h5A5A, 1'b0);
        run_frame(1'b0, 5'h01, 5'h10, 16'h8001, 1'b0);
        run_frame(1'b0, 5'h10, 5'h01, 16'h7FFE, 1'b0);
        run_frame(1'b1, 5'h00, 5'h00, 16'h0000, 1'b0);
        run_frame(1'b1, 5'h1F, 5'h1F, 16'h0000, 1'b0);
        run_frame(1'b1, 5'h15, 5'h0A, 16'h0000, 1'b1);
        run_frame(1'b1, 5'h0A, 5'h15, 16'h0000, 1'b0);
        run_frame(1'b1, 5'h01, 5'h10, 16'h0000, 1'b0);
        run_frame(1'b1, 5'h10, 5'h01, 16'h0000, 1'b0);
        run_frame(1'b1, 5'h03, 5'h07, 16'h0000, 1'b0);
        run_frame(1'b1, 5'h1C, 5'h1B, 16'h0000, 1'b0);
        run_frame(1'b0, 5'h05, 5'h1B, 16'h0001, 1'b0);
        run_frame(1'b1, 5'h05, 5'h1B, 16'h0000, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule